// File: doc/BRIEF.md
# Real-Time Clock Timebase and Update Sequencer

This block is the timebase front end of a real-time clock. A 32.768 kHz clock-enable pulse (`osc_tick`) drives a 15-stage binary prescaler. A byte-wide control register selects how the prescaler behaves and which of its stages feeds a periodic tap. From the prescaler the block produces three things:

- a single-cycle, once-per-second strobe that tells an external time counter to advance;
- an update-pending flag that warns of each strobe a fixed number of ticks in advance;
- a selectable periodic tap that drives a square-wave pin and a sticky periodic-event flag, each behind its own enable.

A neighbouring register supplies an inhibit input. While software rewrites the time, this input stops strobes and hides the pending flag. Reading the control register returns `{pending, divider mode[2:0], rate[3:0]}`. Writes are accepted in every cycle, including while the pending flag is high.

Top module: `rtcb_timebase`

## Requirements
- R1: A write stores `reg_wdata[6:4]` as the divider mode and `reg_wdata[3:0]` as the rate. `reg_rdata` returns `{uip, mode, rate}` from the cycle after the write edge. This also holds while `uip` is 1.
- R2: Bit 7 of a write is ignored. `reg_rdata[7]` always shows the `uip` output.
- R3: With mode 3'b010 the prescaler advances on each `osc_tick`. The first `update_stb` pulse arrives 16384 ticks after the mode leaves a held state. Later pulses arrive every 32768 ticks.
- R4: A mode matching 3'b11x holds the prescaler at zero. While it does, there is no strobe, `uip` is 0 and the tap is low.
- R5: Any mode other than 3'b010 or 3'b11x freezes the prescaler. There are no strobes and the tap is low.
- R6: `uip` rises 8 ticks before each `update_stb` pulse, is 1 during the pulse, and is 0 in the cycle after it.
- R7: While `set_inhibit` is 1, `update_stb` and `uip` are both 0.
- R8: The tap frequency depends on the rate. Rate 1 gives 256 Hz, rate 2 gives 128 Hz, and rates 3 to 15 give 32768 >> (rate-1) Hz. The tap period in ticks is 32768 divided by the frequency.
- R9: Rate 0 keeps the tap low.
- R10: `sqw_out` is the tap gated by `sqw_en`. `pf_flag` is set on each rising edge of the tap while `pie_en` is 1. It is cleared by `pf_clear` or by `rst`. The two enables act independently.
- R11: `rst` does not change the mode, the rate, the prescaler or `uip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (clears the periodic flag only) |
| osc_tick | input | 1 | 32.768 kHz clock-enable pulse |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data `{uip, mode, rate}` |
| set_inhibit | input | 1 | Suppresses strobes and the pending flag |
| sqw_en | input | 1 | Square-wave output enable |
| pie_en | input | 1 | Periodic flag enable |
| pf_clear | input | 1 | Clears the periodic flag |
| update_stb | output | 1 | One-cycle once-per-second update strobe |
| uip | output | 1 | Update-pending flag |
| sqw_out | output | 1 | Square-wave output |
| pf_flag | output | 1 | Sticky periodic-event flag |

## Verification
The bench counts falling edges from the falling edge just after a write edge. With a tick on every cycle, release from hold puts the strobe at count 16384 and the pending rise at count 16376. The next strobe comes 32768 counts later, and the pending flag is low one count after each strobe. Register readback and the tap output follow the write or counter edge by one cycle. `pf_flag` lags a rising tap by one more edge, so the bench samples it only at the following tap rise. The rate sweep measures each tap period between two rising edges and compares it with 32768 divided by the frequency computed in the bench.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;

    typedef enum logic [1:0] {
        MODE_STOP = 2'd0,
        MODE_RUN  = 2'd1,
        MODE_HOLD = 2'd2
    } div_mode_e;

    typedef struct packed {
        logic [2:0] mode;
        logic [3:0] rate;
    } ctrl_t;

    // Classify the 3-bit divider field.
    function automatic div_mode_e decode_mode(input logic [2:0] m);
        if (m == 3'b010)
            return MODE_RUN;
        else if (m[2:1] == 2'b11)
            return MODE_HOLD;
        else
            return MODE_STOP;
    endfunction

    // Prescaler stage whose output forms the tap for a given rate.
    // Stage k toggles with period 2^(k+1) ticks.
    function automatic logic [3:0] rate_stage(input logic [3:0] r);
        case (r)
            4'd1:    return 4'd6;
            4'd2:    return 4'd7;
            default: return r - 4'd2;
        endcase
    endfunction

endpackage

// File: rtl/rtcb_ctrl_reg.sv
module rtcb_ctrl_reg
    import rtcb_pkg::*;
(
    input  logic       clk,
    input  logic       we,
    input  logic [6:0] wdata,
    output ctrl_t      ctrl
);
    // Not reset: the mode and rate survive rst.
    always_ff @(posedge clk) begin
        if (we)
            ctrl <= ctrl_t'(wdata);
    end
endmodule

// File: rtl/rtcb_prescaler.sv
module rtcb_prescaler
    import rtcb_pkg::*;
#(
    parameter int PRESC_W  = 15,
    parameter int UIP_LEAD = 8
) (
    input  logic               clk,
    input  logic               tick,
    input  div_mode_e          mode,
    input  logic               inhibit,
    output logic [PRESC_W-1:0] cnt,
    output logic               stb_q,
    output logic               uip_q
);
    // Count value just before the half-way rollover that marks an update.
    localparam logic [PRESC_W-1:0] UPD_AT = PRESC_W'((1 << (PRESC_W - 1)) - 1);
    localparam logic [PRESC_W-1:0] UIP_AT = UPD_AT - PRESC_W'(UIP_LEAD);

    logic run;
    assign run = (mode == MODE_RUN);

    always_ff @(posedge clk) begin
        if (mode == MODE_HOLD)
            cnt <= '0;
        else if (run && tick)
            cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        stb_q <= run && tick && (cnt == UPD_AT) && uip_q && !inhibit;
    end

    always_ff @(posedge clk) begin
        if (!run || inhibit || stb_q)
            uip_q <= 1'b0;
        else if (tick && cnt == UIP_AT)
            uip_q <= 1'b1;
    end
endmodule

// File: rtl/rtcb_tap.sv
module rtcb_tap
    import rtcb_pkg::*;
#(
    parameter int PRESC_W = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PRESC_W-1:0] cnt,
    input  div_mode_e          mode,
    input  logic [3:0]         rate,
    input  logic               sqw_en,
    input  logic               pie_en,
    input  logic               pf_clear,
    output logic               sqw_out,
    output logic               pf_flag
);
    logic       tap;
    logic       tap_q;
    logic [3:0] stage;

    always_comb begin
        stage = rate_stage(rate);
        tap   = 1'b0;
        if (mode == MODE_RUN && rate != 4'd0)
            tap = cnt[stage];
    end

    assign sqw_out = sqw_en & tap;

    always_ff @(posedge clk) begin
        tap_q <= tap;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pf_flag <= 1'b0;
        else if (pie_en && tap && !tap_q)
            pf_flag <= 1'b1;
        else if (pf_clear)
            pf_flag <= 1'b0;
    end
endmodule

// File: rtl/rtcb_timebase.sv
module rtcb_timebase
    import rtcb_pkg::*;
#(
    parameter int PRESC_W  = 15,
    parameter int UIP_LEAD = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       set_inhibit,
    input  logic       sqw_en,
    input  logic       pie_en,
    input  logic       pf_clear,
    output logic       update_stb,
    output logic       uip,
    output logic       sqw_out,
    output logic       pf_flag
);
    ctrl_t              ctrl;
    div_mode_e          mode;
    logic [PRESC_W-1:0] cnt;
    logic               stb_q;
    logic               uip_q;
    logic               wdata_unused;

    // Bit 7 of a write is ignored.
    assign wdata_unused = reg_wdata[7];

    rtcb_ctrl_reg u_reg (
        .clk   (clk),
        .we    (reg_we),
        .wdata (reg_wdata[6:0]),
        .ctrl  (ctrl)
    );

    assign mode = decode_mode(ctrl.mode);

    rtcb_prescaler #(
        .PRESC_W  (PRESC_W),
        .UIP_LEAD (UIP_LEAD)
    ) u_presc (
        .clk     (clk),
        .tick    (osc_tick),
        .mode    (mode),
        .inhibit (set_inhibit),
        .cnt     (cnt),
        .stb_q   (stb_q),
        .uip_q   (uip_q)
    );

    rtcb_tap #(
        .PRESC_W (PRESC_W)
    ) u_tap (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .mode     (mode),
        .rate     (ctrl.rate),
        .sqw_en   (sqw_en),
        .pie_en   (pie_en),
        .pf_clear (pf_clear),
        .sqw_out  (sqw_out),
        .pf_flag  (pf_flag)
    );

    assign update_stb = stb_q & ~set_inhibit;
    assign uip        = uip_q & ~set_inhibit;
    assign reg_rdata  = {uip, ctrl.mode, ctrl.rate};
endmodule

// File: rtl/rtcb_checker.sv
module rtcb_checker (
    input logic       clk,
    input logic       rst,
    input logic       reg_we,
    input logic [7:0] reg_rdata,
    input logic       set_inhibit,
    input logic       pie_en,
    input logic       update_stb,
    input logic       uip,
    input logic       sqw_out,
    input logic       pf_flag
);
    // R7
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        set_inhibit |-> (!update_stb && !uip));

    // R6
    stb_has_uip_chk: assert property (@(posedge clk) disable iff (rst)
        update_stb |-> uip);

    // R6
    uip_drop_chk: assert property (@(posedge clk) disable iff (rst)
        update_stb |=> !uip);

    // R4
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[6:5] == 2'b11 && !reg_we) |=> (!update_stb && !uip && !sqw_out));

    // R9
    rate_off_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[3:0] == 4'd0) |-> !sqw_out);

    // R10
    pf_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_flag) |-> $past(pie_en));

    // R11
    rst_keep_chk: assert property (@(posedge clk)
        (rst && !reg_we) |=> (reg_rdata[6:0] == $past(reg_rdata[6:0])));
endmodule

bind rtcb_timebase rtcb_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_rdata   (reg_rdata),
    .set_inhibit (set_inhibit),
    .pie_en      (pie_en),
    .update_stb  (update_stb),
    .uip         (uip),
    .sqw_out     (sqw_out),
    .pf_flag     (pf_flag)
);

// File: tb/sim_rtcb_timebase.sv
`timescale 1ns/1ps
module sim_rtcb_timebase;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b1;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       set_inhibit = 1'b0;
    logic       sqw_en = 1'b0;
    logic       pie_en = 1'b0;
    logic       pf_clear = 1'b0;
    logic [7:0] reg_rdata;
    logic       update_stb, uip, sqw_out, pf_flag;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rtcb_timebase u0 (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_inhibit(set_inhibit),
        .sqw_en(sqw_en), .pie_en(pie_en), .pf_clear(pf_clear),
        .update_stb(update_stb), .uip(uip), .sqw_out(sqw_out), .pf_flag(pf_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        pf_clear = 1'b1;
        @(negedge clk);
        pf_clear = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, first_uip, stb_n, cnt_a, cnt_b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R10)
        chk(pf_flag == 1'b0, "R10 reset pf", pf_flag, 0);
        chk(update_stb == 1'b0, "R3 reset strobe", update_stb, 0);

        // R1 / R2 / R4: hold via 110, then 111 with bit 7 set
        wr(8'h60);
        chk(reg_rdata == 8'h60, "R1 readback", reg_rdata, 8'h60);
        wr(8'hF0);
        chk(reg_rdata == 8'h70, "R2 bit7 ignored", reg_rdata, 8'h70);
        wr(8'h73);
        sqw_en = 1'b1;
        cnt_a = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (sqw_out || update_stb || uip) cnt_a++;
        end
        chk(cnt_a == 0, "R4 hold quiet", cnt_a, 0);
        sqw_en = 1'b0;

        // R3 / R6 / R11 / R1: release, first update at 16384
        wr(8'h20);
        n = 0; first_uip = -1; stb_n = -1;
        while (stb_n < 0 && n < 20000) begin
            @(negedge clk);
            n++;
            if (n == 16378) rst = 1'b1;
            if (n == 16379) begin
                rst = 1'b0;
                chk(reg_rdata == 8'hA0, "R11 rst keeps state", reg_rdata, 8'hA0);
                reg_we = 1'b1;
                reg_wdata = 8'h23;
            end
            if (n == 16380) begin
                reg_we = 1'b0;
                chk(reg_rdata == 8'hA3, "R1 write during uip", reg_rdata, 8'hA3);
            end
            if (uip && first_uip < 0) first_uip = n;
            if (update_stb) stb_n = n;
        end
        chk(stb_n == 16384, "R3 first update", stb_n, 16384);
        chk(first_uip == 16376, "R6 uip lead", first_uip, 16376);
        @(negedge clk);
        n++;
        chk(uip == 1'b0, "R6 uip drop", uip, 0);

        // R3 / R6: one second later
        first_uip = -1; stb_n = -1;
        while (stb_n < 0 && n < 60000) begin
            @(negedge clk);
            n++;
            if (uip && first_uip < 0) first_uip = n;
            if (update_stb) stb_n = n;
        end
        chk(stb_n == 49152, "R3 period", stb_n, 49152);
        chk(first_uip == 49144, "R6 uip lead 2", first_uip, 49144);

        // R7: inhibit across a full second
        @(negedge clk);
        set_inhibit = 1'b1;
        cnt_a = 0;
        for (int i = 0; i < 32800; i++) begin
            @(negedge clk);
            if (update_stb || uip) cnt_a++;
        end
        chk(cnt_a == 0, "R7 inhibit", cnt_a, 0);
        set_inhibit = 1'b0;

        // R8 / R9 / R10: rate sweep
        sqw_en = 1'b1;
        pie_en = 1'b1;
        for (int rs = 0; rs < 16; rs++) begin
            int freq, per;
            wr({1'b0, 3'b010, rs[3:0]});
            if (rs == 0) begin
                pie_en = 1'b0;
                pulse_clear();
                pie_en = 1'b1;
                cnt_a = 0;
                for (int i = 0; i < 300; i++) begin
                    @(negedge clk);
                    if (sqw_out || pf_flag) cnt_a++;
                end
                chk(cnt_a == 0, "R9 rate off", cnt_a, 0);
            end else begin
                logic prev;
                freq = (rs == 1) ? 256 : (rs == 2) ? 128 : (32768 >> (rs - 1));
                per  = 32768 / freq;
                prev = sqw_out;
                cnt_a = -1;
                for (int i = 0; i < 2 * per + 4 && cnt_a < 0; i++) begin
                    @(negedge clk);
                    if (sqw_out && !prev) cnt_a = i;
                    prev = sqw_out;
                end
                cnt_b = -1;
                for (int i = 1; i < 2 * per + 4 && cnt_b < 0; i++) begin
                    @(negedge clk);
                    if (sqw_out && !prev) cnt_b = i;
                    prev = sqw_out;
                end
                chk(cnt_b == per, $sformatf("R8 period rate %0d", rs), cnt_b, per);
                chk(pf_flag == 1'b1, $sformatf("R10 pf set rate %0d", rs), pf_flag, 1);
            end
        end

        // R10: enables act independently (rate 3, period 4)
        wr(8'h23);
        sqw_en = 1'b0;
        pie_en = 1'b1;
        pulse_clear();
        cnt_a = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sqw_out) cnt_a++;
        end
        chk(cnt_a == 0, "R10 sqw disabled", cnt_a, 0);
        chk(pf_flag == 1'b1, "R10 pf alone", pf_flag, 1);
        sqw_en = 1'b1;
        pie_en = 1'b0;
        pulse_clear();
        cnt_a = 0; cnt_b = 0;
        begin
            logic prev;
            prev = sqw_out;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (pf_flag) cnt_a++;
                if (sqw_out && !prev) cnt_b++;
                prev = sqw_out;
            end
        end
        chk(cnt_a == 0, "R10 pf disabled", cnt_a, 0);
        chk(cnt_b >= 4, "R10 sqw alone", cnt_b, 5);

        // R10 / R11: rst clears pf, keeps register
        pie_en = 1'b1;
        repeat (10) @(negedge clk);
        chk(pf_flag == 1'b1, "R10 pf before rst", pf_flag, 1);
        pie_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(pf_flag == 1'b0, "R10 rst clears pf", pf_flag, 0);
        chk(reg_rdata[6:0] == 7'h23, "R11 rst keeps rate", reg_rdata[6:0], 7'h23);

        // R5: stopped mode
        wr(8'h03);
        cnt_a = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (sqw_out || update_stb || uip) cnt_a++;
        end
        chk(cnt_a == 0, "R5 stop quiet", cnt_a, 0);
        chk(reg_rdata == 8'h03, "R5 readback", reg_rdata, 8'h03);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule